// File: doc/BRIEF.md
# Buck Converter Protection Sequencer

This block is the digital supervisor of a single-phase synchronous buck controller. It reads a set of comparator flags (supply above its rising level, supply below its falling level, feedback over-voltage, feedback under-voltage, over-current, shutdown request), plus a slow timer tick. From these it decides when the power stage may switch, when both gates must be held off, and when the low-side switch must be forced on to discharge the output.

After a supply power-on, the sequencer runs a short capture window. In that window the low-side gate is floated so the over-current level can be sampled. It then ramps an internal reference from zero up to the regulation target, and regulates at that target. An over-voltage is latched with the low side held on until the supply is cycled. Over-current and under-voltage enter a wait-and-retry loop, each with its own delay. A shutdown request parks the stage until it is withdrawn. All durations are counted in timer ticks, so the same logic serves any tick rate.

Top module: `buck_prot_seq`

## Requirements
- R1: After a synchronous reset (rst_n low) the state is RESET, with state_code 0, pwm_en 0, gates_off 1, lowside_on 0 and ref_level 0. The state_code encoding is RESET 0, CAPTURE 1, SOFTSTART 2, RUN 3, HICCUP 4, OVP 5, SHUTDOWN 6.
- R2: Supply handling uses hysteresis. supply_above_rise in RESET moves to CAPTURE on the next clock. supply_below_fall in any state moves to RESET on the next clock and wins over every other input. supply_above_rise has no effect outside RESET.
- R3: CAPTURE lasts exactly CAP_TICKS ticks. Throughout it, lowside_float and ocp_sample are 1 and pwm_en is 0. When it ends, the state is SOFTSTART with lowside_float and ocp_sample at 0. A shutdown request during CAPTURE is not acted on.
- R4: SOFTSTART starts with ref_level 0 and adds 1 per tick. ref_level never goes above REF_LEVEL and never decreases within SOFTSTART. When the internal ramp passes REF_LEVEL, which takes REF_LEVEL+1 ticks, the state becomes RUN with ref_level equal to REF_LEVEL.
- R5: fb_over in any state other than RESET enters OVP on the next clock. In OVP, pwm_en is 0, lowside_on is 1 and ovp_flag is 1. OVP is left only through supply_below_fall; a shutdown request or supply_above_rise has no effect on it.
- R6: fb_over while in RESET sets lowside_on to 1 and gates_off to 0 on the next clock. This stays set, even after fb_over drops, until the state leaves RESET, and it is cleared on entry to CAPTURE.
- R7: fb_under is acted on only in RUN. In SOFTSTART it has no effect on the state or the ramp.
- R8: fb_under in RUN enters HICCUP with hiccup_uv 1, gates_off 1 and pwm_en 0. After UV_WAIT_TICKS ticks the state returns to SOFTSTART with ref_level 0.
- R9: oc_trip in SOFTSTART or RUN enters HICCUP with hiccup_uv 0 and gates_off 1. After OC_RETRY_MULT*(REF_LEVEL+1) ticks, which is that many soft-start intervals, the state returns to SOFTSTART.
- R10: Priority, highest first, is supply fall, then over-voltage, then shutdown, then over-current, then under-voltage. oc_trip together with fb_under in RUN gives hiccup_uv 0, and over-voltage preempts a pending shutdown.
- R11: sd_request in SOFTSTART, RUN or HICCUP enters SHUTDOWN, where gates_off is 1 and oc_trip and fb_under are ignored. Dropping sd_request returns to SOFTSTART with ref_level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timer tick pulse |
| supply_above_rise | input | 1 | Supply is above the rising power-on level |
| supply_below_fall | input | 1 | Supply is below the falling power-on level |
| fb_over | input | 1 | Feedback above the over-voltage level |
| fb_under | input | 1 | Feedback below the under-voltage level |
| oc_trip | input | 1 | Sampled low-side current above the captured limit |
| sd_request | input | 1 | Shutdown pin below its threshold |
| pwm_en | output | 1 | Switching allowed |
| gates_off | output | 1 | Both gates forced off |
| lowside_on | output | 1 | Low-side gate forced on, high side off |
| lowside_float | output | 1 | Low-side driver tri-stated for level capture |
| ocp_sample | output | 1 | Over-current level sample enable |
| ref_level | output | RAMP_W | Effective regulation reference code |
| state_code | output | 3 | Current sequencer state |
| ovp_flag | output | 1 | Over-voltage latched |
| hiccup_uv | output | 1 | Current retry wait was caused by under-voltage |

## Verification
The sequencer is driven through a full power-up and then through each fault pattern one at a time: over-voltage before power-on, under-voltage during the ramp and during regulation, over-current alone, over-current together with under-voltage, shutdown with a concurrent over-current, and over-voltage followed by shutdown and supply re-rise. Comparing the retry length after an under-voltage with the length after an over-current separates the two delay paths. Probing one tick before and at the end of each timed window pins the exact tick counts. The simultaneous-fault and shutdown patterns tell apart a correct priority order from a swapped one, and a supply re-rise inside the latched over-voltage state tells a true latch from a restart.

// File: rtl/bps_pkg.sv
// Shared types for the buck protection sequencer.
package bps_pkg;

    // Sequencer state; the encoding is visible at the state_code port.
    typedef enum logic [2:0] {
        ST_RESET     = 3'd0,
        ST_CAPTURE   = 3'd1,
        ST_SOFTSTART = 3'd2,
        ST_RUN       = 3'd3,
        ST_HICCUP    = 3'd4,
        ST_OVP       = 3'd5,
        ST_SHUTDOWN  = 3'd6
    } seq_state_e;

endpackage

// File: rtl/bps_tick_timer.sv
// Down-counting tick timer shared by the capture window and both retry waits.
// Assumes: load is a single-cycle pulse on entry to a timed state and the
// load value is at least 1. expire pulses on the tick that ends the window.
module bps_tick_timer #(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);

    logic [TMR_W-1:0] cnt_q;

    // Load a new window, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The window ends on the tick that takes the count from one to zero.
    always_comb begin
        expire = tick && (cnt_q == TMR_W'(1));
    end

endmodule

// File: rtl/bps_ramp.sv
// Soft-start reference ramp. Counts up one code per tick while soft-start is
// active, is held at zero otherwise, and reports when it has passed the
// regulation target. The reference presented outward saturates at the target.
// Assumes: REF_LEVEL + 1 fits in RAMP_W bits.
module bps_ramp #(
    parameter int RAMP_W    = 8,
    parameter int REF_LEVEL = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_active,
    input  logic              run_active,
    input  logic              tick,
    output logic              ramp_done,
    output logic [RAMP_W-1:0] ref_out
);

    localparam logic [RAMP_W-1:0] TARGET = RAMP_W'(REF_LEVEL);

    logic [RAMP_W-1:0] ramp_q;

    // Ramp register: cleared outside soft-start, steps once per tick inside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp_q <= '0;
        end else if (!ss_active) begin
            ramp_q <= '0;
        end else if (tick && !ramp_done) begin
            ramp_q <= ramp_q + 1'b1;
        end
    end

    // Completion flag and saturated reference selection.
    always_comb begin
        ramp_done = (ramp_q > TARGET);
        if (run_active) begin
            ref_out = TARGET;
        end else if (ss_active) begin
            ref_out = ramp_done ? TARGET : ramp_q;
        end else begin
            ref_out = '0;
        end
    end

endmodule

// File: rtl/bps_fsm.sv
// Protection state machine. Arbitrates supply, over-voltage, shutdown,
// over-current and under-voltage in that priority and requests timed windows
// from the shared timer. Assumes all flag inputs are already synchronous.
module bps_fsm
    import bps_pkg::*;
#(
    parameter int TMR_W    = 10,
    parameter int CAP_TICKS = 4,
    parameter int UV_WAIT   = 40,
    parameter int OC_WAIT   = 804
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_above_rise,
    input  logic             supply_below_fall,
    input  logic             fb_over,
    input  logic             fb_under,
    input  logic             oc_trip,
    input  logic             sd_request,
    input  logic             tmr_expire,
    input  logic             ramp_done,
    output seq_state_e       state_q,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             uv_cause_q,
    output logic             pre_ovp_q
);

    localparam logic [TMR_W-1:0] CAP_V = TMR_W'(CAP_TICKS);
    localparam logic [TMR_W-1:0] UV_V  = TMR_W'(UV_WAIT);
    localparam logic [TMR_W-1:0] OC_V  = TMR_W'(OC_WAIT);

    seq_state_e state_n;
    logic       enter_uv;
    logic       entering_hiccup;

    // Next-state selection in priority order.
    always_comb begin
        state_n  = state_q;
        enter_uv = 1'b0;
        if (supply_below_fall) begin
            state_n = ST_RESET;
        end else begin
            case (state_q)
                ST_RESET: begin
                    if (supply_above_rise) state_n = ST_CAPTURE;
                end
                ST_OVP: begin
                    state_n = ST_OVP;
                end
                ST_CAPTURE: begin
                    if (fb_over)         state_n = ST_OVP;
                    else if (tmr_expire) state_n = ST_SOFTSTART;
                end
                ST_SOFTSTART: begin
                    if (fb_over)         state_n = ST_OVP;
                    else if (sd_request) state_n = ST_SHUTDOWN;
                    else if (oc_trip)    state_n = ST_HICCUP;
                    else if (ramp_done)  state_n = ST_RUN;
                end
                ST_RUN: begin
                    if (fb_over)         state_n = ST_OVP;
                    else if (sd_request) state_n = ST_SHUTDOWN;
                    else if (oc_trip)    state_n = ST_HICCUP;
                    else if (fb_under) begin
                        state_n  = ST_HICCUP;
                        enter_uv = 1'b1;
                    end
                end
                ST_HICCUP: begin
                    if (fb_over)         state_n = ST_OVP;
                    else if (sd_request) state_n = ST_SHUTDOWN;
                    else if (tmr_expire) state_n = ST_SOFTSTART;
                end
                ST_SHUTDOWN: begin
                    if (fb_over)          state_n = ST_OVP;
                    else if (!sd_request) state_n = ST_SOFTSTART;
                end
                default: begin
                    state_n = ST_RESET;
                end
            endcase
        end
    end

    // Timer request on entry to a timed state, with the window for its cause.
    always_comb begin
        entering_hiccup = (state_n == ST_HICCUP) && (state_q != ST_HICCUP);
        tmr_load = entering_hiccup ||
                   ((state_n == ST_CAPTURE) && (state_q != ST_CAPTURE));
        if (state_n == ST_CAPTURE) begin
            tmr_val = CAP_V;
        end else if (enter_uv) begin
            tmr_val = UV_V;
        end else begin
            tmr_val = OC_V;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_n;
        end
    end

    // Records whether the current retry wait was caused by under-voltage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uv_cause_q <= 1'b0;
        end else if (entering_hiccup) begin
            uv_cause_q <= enter_uv;
        end
    end

    // Pre-power-on over-voltage hold, kept only while the next state is RESET.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_ovp_q <= 1'b0;
        end else if (state_n == ST_RESET) begin
            pre_ovp_q <= pre_ovp_q | fb_over;
        end else begin
            pre_ovp_q <= 1'b0;
        end
    end

endmodule

// File: rtl/buck_prot_seq.sv
// Buck converter protection sequencer top. Ties the state machine, the
// shared tick timer and the soft-start ramp together and decodes the gate
// control and status outputs from the sequencer state.
// Assumes: tick is a single-cycle pulse, inputs are synchronous to clk.
module buck_prot_seq
    import bps_pkg::*;
#(
    parameter int RAMP_W        = 8,
    parameter int REF_LEVEL     = 200,
    parameter int CAP_TICKS     = 4,
    parameter int UV_WAIT_TICKS = 40,
    parameter int OC_RETRY_MULT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              supply_above_rise,
    input  logic              supply_below_fall,
    input  logic              fb_over,
    input  logic              fb_under,
    input  logic              oc_trip,
    input  logic              sd_request,
    output logic              pwm_en,
    output logic              gates_off,
    output logic              lowside_on,
    output logic              lowside_float,
    output logic              ocp_sample,
    output logic [RAMP_W-1:0] ref_level,
    output logic [2:0]        state_code,
    output logic              ovp_flag,
    output logic              hiccup_uv
);

    localparam int SS_TICKS = REF_LEVEL + 1;
    localparam int OC_WAIT  = OC_RETRY_MULT * SS_TICKS;
    localparam int MAX_AB   = (CAP_TICKS > UV_WAIT_TICKS) ? CAP_TICKS : UV_WAIT_TICKS;
    localparam int TMR_MAX  = (MAX_AB > OC_WAIT) ? MAX_AB : OC_WAIT;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);

    seq_state_e       state;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             ramp_done;
    logic             uv_cause;
    logic             pre_ovp;
    logic             ss_active;
    logic             run_active;

    bps_fsm #(
        .TMR_W     (TMR_W),
        .CAP_TICKS (CAP_TICKS),
        .UV_WAIT   (UV_WAIT_TICKS),
        .OC_WAIT   (OC_WAIT)
    ) u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .supply_above_rise (supply_above_rise),
        .supply_below_fall (supply_below_fall),
        .fb_over           (fb_over),
        .fb_under          (fb_under),
        .oc_trip           (oc_trip),
        .sd_request        (sd_request),
        .tmr_expire        (tmr_expire),
        .ramp_done         (ramp_done),
        .state_q           (state),
        .tmr_load          (tmr_load),
        .tmr_val           (tmr_val),
        .uv_cause_q        (uv_cause),
        .pre_ovp_q         (pre_ovp)
    );

    bps_tick_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick),
        .expire   (tmr_expire)
    );

    bps_ramp #(
        .RAMP_W    (RAMP_W),
        .REF_LEVEL (REF_LEVEL)
    ) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss_active  (ss_active),
        .run_active (run_active),
        .tick       (tick),
        .ramp_done  (ramp_done),
        .ref_out    (ref_level)
    );

    // Output decode from the sequencer state.
    always_comb begin
        ss_active     = (state == ST_SOFTSTART);
        run_active    = (state == ST_RUN);
        pwm_en        = ss_active || run_active;
        lowside_on    = (state == ST_OVP) || pre_ovp;
        gates_off     = !pwm_en && !lowside_on;
        lowside_float = (state == ST_CAPTURE);
        ocp_sample    = (state == ST_CAPTURE);
        ovp_flag      = (state == ST_OVP);
        hiccup_uv     = (state == ST_HICCUP) && uv_cause;
        state_code    = state;
    end

endmodule

// File: rtl/buck_prot_seq_chk.sv
// Property checker for the buck protection sequencer, bound to the top.
// Observes ports only.
module buck_prot_seq_chk #(
    parameter int RAMP_W    = 8,
    parameter int REF_LEVEL = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_above_rise,
    input logic              supply_below_fall,
    input logic              fb_over,
    input logic              fb_under,
    input logic              oc_trip,
    input logic              sd_request,
    input logic              pwm_en,
    input logic              lowside_on,
    input logic              lowside_float,
    input logic              ocp_sample,
    input logic [RAMP_W-1:0] ref_level,
    input logic [2:0]        state_code
);

    // R2
    fall_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_below_fall |=> (state_code == 3'd0));

    // R3
    capture_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0) && supply_above_rise && !supply_below_fall
        |=> (state_code == 3'd1) && ocp_sample && lowside_float);

    // R4
    ramp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2) && ($past(state_code) == 3'd2)
        |-> (ref_level >= $past(ref_level)));

    // R4
    ref_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_level <= RAMP_W'(REF_LEVEL));

    // R5
    ovp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5) && !supply_below_fall |=> (state_code == 3'd5));

    // R5
    gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_en && lowside_on));

    // R7
    uv_softstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2) && fb_under && !supply_below_fall && !fb_over
        && !sd_request && !oc_trip |=> (state_code != 3'd4));

    // R11
    sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd6) && sd_request && !supply_below_fall && !fb_over
        |=> (state_code == 3'd6));

endmodule

bind buck_prot_seq buck_prot_seq_chk #(
    .RAMP_W    (RAMP_W),
    .REF_LEVEL (REF_LEVEL)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .supply_above_rise (supply_above_rise),
    .supply_below_fall (supply_below_fall),
    .fb_over           (fb_over),
    .fb_under          (fb_under),
    .oc_trip           (oc_trip),
    .sd_request        (sd_request),
    .pwm_en            (pwm_en),
    .lowside_on        (lowside_on),
    .lowside_float     (lowside_float),
    .ocp_sample        (ocp_sample),
    .ref_level         (ref_level),
    .state_code        (state_code)
);

// File: tb/buck_prot_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected port values, the monitor
// compares them at the following falling clock edge.
module buck_prot_seq_bench;

    localparam int RAMP_W = 8;
    localparam int REF    = 10;
    localparam int CAP    = 3;
    localparam int UVW    = 7;
    localparam int OCM    = 4;
    localparam int OCW    = OCM * (REF + 1);

    localparam int K_STATE = 0;
    localparam int K_PWM   = 1;
    localparam int K_OFF   = 2;
    localparam int K_LOW   = 3;
    localparam int K_FLOAT = 4;
    localparam int K_SAMP  = 5;
    localparam int K_REF   = 6;
    localparam int K_OVP   = 7;
    localparam int K_UV    = 8;

    typedef struct {
        int    kind;
        int    exp;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic supply_above_rise = 1'b0;
    logic supply_below_fall = 1'b0;
    logic fb_over = 1'b0;
    logic fb_under = 1'b0;
    logic oc_trip = 1'b0;
    logic sd_request = 1'b0;
    logic pwm_en, gates_off, lowside_on, lowside_float, ocp_sample;
    logic ovp_flag, hiccup_uv;
    logic [RAMP_W-1:0] ref_level;
    logic [2:0] state_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;

    buck_prot_seq #(
        .RAMP_W        (RAMP_W),
        .REF_LEVEL     (REF),
        .CAP_TICKS     (CAP),
        .UV_WAIT_TICKS (UVW),
        .OC_RETRY_MULT (OCM)
    ) u_buck_prot_seq (
        .clk               (clk),
        .rst_n             (rst_n),
        .tick              (tick),
        .supply_above_rise (supply_above_rise),
        .supply_below_fall (supply_below_fall),
        .fb_over           (fb_over),
        .fb_under          (fb_under),
        .oc_trip           (oc_trip),
        .sd_request        (sd_request),
        .pwm_en            (pwm_en),
        .gates_off         (gates_off),
        .lowside_on        (lowside_on),
        .lowside_float     (lowside_float),
        .ocp_sample        (ocp_sample),
        .ref_level         (ref_level),
        .state_code        (state_code),
        .ovp_flag          (ovp_flag),
        .hiccup_uv         (hiccup_uv)
    );

    function automatic int port_val(int kind);
        case (kind)
            K_STATE: return int'(state_code);
            K_PWM:   return int'(pwm_en);
            K_OFF:   return int'(gates_off);
            K_LOW:   return int'(lowside_on);
            K_FLOAT: return int'(lowside_float);
            K_SAMP:  return int'(ocp_sample);
            K_REF:   return int'(ref_level);
            K_OVP:   return int'(ovp_flag);
            default: return int'(hiccup_uv);
        endcase
    endfunction

    // Monitor: pops every queued expectation and compares at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            automatic item_t it = q.pop_front();
            automatic int act = port_val(it.kind);
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%0d expected=%0d",
                         it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(int kind, int exp, string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
            step();
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        push(K_STATE, 0, "R1"); push(K_PWM, 0, "R1");
        push(K_OFF, 1, "R1"); push(K_LOW, 0, "R1"); push(K_REF, 0, "R1");
        settle();
        rst_n = 1'b1;
        step();

        // R6 over-voltage before power-on
        fb_over = 1'b1; step();
        push(K_LOW, 1, "R6"); push(K_OFF, 0, "R6"); push(K_STATE, 0, "R6");
        settle();
        fb_over = 1'b0; step();
        push(K_LOW, 1, "R6"); settle();

        // R2 power-on into capture, R6 hold cleared
        supply_above_rise = 1'b1; step();
        supply_above_rise = 1'b0;
        push(K_STATE, 1, "R2"); push(K_LOW, 0, "R6");
        push(K_FLOAT, 1, "R3"); push(K_SAMP, 1, "R3"); push(K_PWM, 0, "R3");
        settle();

        // R3 capture window length, shutdown ignored inside it
        sd_request = 1'b1;
        tick_n(CAP - 1);
        push(K_STATE, 1, "R3"); settle();
        sd_request = 1'b0;
        tick_n(1);
        push(K_STATE, 2, "R3"); push(K_SAMP, 0, "R3"); push(K_FLOAT, 0, "R3");
        push(K_REF, 0, "R4"); push(K_PWM, 1, "R4");
        settle();

        // R4 ramp, R7 under-voltage ignored in soft-start
        tick_n(4);
        push(K_REF, 4, "R4"); settle();
        fb_under = 1'b1;
        tick_n(1);
        push(K_STATE, 2, "R7"); push(K_REF, 5, "R7"); settle();
        fb_under = 1'b0;
        tick_n(REF - 5);
        push(K_STATE, 2, "R4"); push(K_REF, REF, "R4"); settle();
        tick_n(1);
        push(K_STATE, 3, "R4"); push(K_REF, REF, "R4"); settle();

        // R2 supply re-rise has no effect while running
        supply_above_rise = 1'b1; step(); supply_above_rise = 1'b0;
        push(K_STATE, 3, "R2"); settle();

        // R8 under-voltage hiccup
        fb_under = 1'b1; step(); fb_under = 1'b0;
        push(K_STATE, 4, "R8"); push(K_UV, 1, "R8"); push(K_OFF, 1, "R8");
        push(K_PWM, 0, "R8");
        settle();
        tick_n(UVW - 1);
        push(K_STATE, 4, "R8"); settle();
        tick_n(1);
        push(K_STATE, 2, "R8"); push(K_REF, 0, "R8"); settle();

        // R9 over-current hiccup from run
        tick_n(REF + 1);
        push(K_STATE, 3, "R9"); settle();
        oc_trip = 1'b1; step(); oc_trip = 1'b0;
        push(K_STATE, 4, "R9"); push(K_UV, 0, "R9"); push(K_OFF, 1, "R9");
        settle();
        tick_n(OCW - 1);
        push(K_STATE, 4, "R9"); settle();
        tick_n(1);
        push(K_STATE, 2, "R9"); settle();

        // R10 over-current wins over under-voltage
        tick_n(REF + 1);
        oc_trip = 1'b1; fb_under = 1'b1; step();
        oc_trip = 1'b0; fb_under = 1'b0;
        push(K_STATE, 4, "R10"); push(K_UV, 0, "R10"); settle();
        tick_n(UVW);
        push(K_STATE, 4, "R10"); settle();
        tick_n(OCW - UVW);
        push(K_STATE, 2, "R10"); settle();

        // R11 shutdown from soft-start, over-current ignored in it
        sd_request = 1'b1; step();
        push(K_STATE, 6, "R11"); push(K_OFF, 1, "R11"); settle();
        oc_trip = 1'b1; fb_under = 1'b1; step();
        push(K_STATE, 6, "R11"); settle();
        oc_trip = 1'b0; fb_under = 1'b0; sd_request = 1'b0; step();
        push(K_STATE, 2, "R11"); push(K_REF, 0, "R11"); settle();

        // R5 latched over-voltage, R10 over shutdown
        tick_n(REF + 1);
        fb_over = 1'b1; sd_request = 1'b1; step();
        fb_over = 1'b0;
        push(K_STATE, 5, "R10"); push(K_LOW, 1, "R5"); push(K_PWM, 0, "R5");
        push(K_OVP, 1, "R5"); push(K_OFF, 0, "R5");
        settle();
        step();
        push(K_STATE, 5, "R5"); settle();
        sd_request = 1'b0; supply_above_rise = 1'b1; step();
        supply_above_rise = 1'b0;
        push(K_STATE, 5, "R5"); settle();
        supply_below_fall = 1'b1; step(); supply_below_fall = 1'b0;
        push(K_STATE, 0, "R2"); push(K_LOW, 0, "R5"); push(K_OFF, 1, "R2");
        settle();
        supply_above_rise = 1'b1; step(); supply_above_rise = 1'b0;
        push(K_STATE, 1, "R2"); settle();

        // R2 supply fall wins over a simultaneous rise
        supply_above_rise = 1'b1; supply_below_fall = 1'b1; step();
        supply_above_rise = 1'b0; supply_below_fall = 1'b0;
        push(K_STATE, 0, "R2"); settle();

        settle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule